// File: doc/BRIEF.md
# Parallel-to-Serial Display Link Transmitter

This block turns a 21-bit parallel pixel word into three serial data lanes plus a forwarded-clock lane. It captures one word per pixel-clock period, on the falling edge of the pixel clock. It splits the word into three 7-bit slices and shifts each slice out, lowest bit first, on a fast clock running at seven times the pixel rate. The fast clock is phase-aligned with the pixel clock. A receiver finds word boundaries from the fixed 7-bit pattern carried on the forwarded-clock lane, which repeats once per pixel period.

The pixel-domain logic has only two jobs. It holds the captured word, and it toggles a marker on every rising pixel edge. The fast domain watches that marker to place its slot counter. Each captured word is moved into the shifters at the next word boundary, which is the rising pixel edge that follows the capture.

An active-low shutdown input clears every register at once, without waiting for a clock edge, and forces all four outputs low. After release the outputs stay low until a whole word has been captured and loaded. Transmission then begins at the first slot of a word.

Top module: `pixlink_tx`

## Requirements
- R1: The word on `pix_data` is sampled at the falling edge of `pix_clk`. A change of `pix_data` between that falling edge and the next rising edge has no effect on the transmitted word.
- R2: In each word period, lane L (`ser_lane[L]`) sends bits `pix_data[7L]` through `pix_data[7L+6]`, one per fast-clock cycle, lowest-numbered bit first. Lane 0 carries bits 0–6, lane 1 carries bits 7–13 and lane 2 carries bits 14–20.
- R3: While transmitting, `fwd_clk` sends the sequence 1,1,0,0,0,1,1 in slots 0 to 6 of every word period. Slot 0 is the first bit of each data lane, so the single falling transition falls two bit times after each word starts.
- R4: A word captured at a falling `pix_clk` edge has its slot-0 bits driven in the fast-clock cycle that begins at the next rising `pix_clk` edge.
- R5: While `shdn_n` is low, `ser_lane` and `fwd_clk` are 0, and they go to 0 at once when `shdn_n` falls, without waiting for a clock edge.
- R6: After `shdn_n` rises, all outputs stay 0 until the first word captured after the release is loaded. The first nonzero output is slot 0 of that word.
- R7: Once transmission has started, every pixel period carries exactly one new word: the one captured at the falling edge just before that period. No word is skipped and none is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; the word is captured on its falling edge |
| fast_clk | input | 1 | Bit clock at seven times the pixel rate, phase-aligned with `pix_clk` |
| shdn_n | input | 1 | Active-low shutdown and asynchronous clear |
| pix_data | input | 21 | Parallel pixel word |
| ser_lane | output | 3 | Serial data lanes, one bit per lane per fast-clock cycle |
| fwd_clk | output | 1 | Forwarded-clock lane carrying the per-word framing pattern |

## Verification
The hardest situation to reach is a shutdown release at an arbitrary phase of the pixel clock. Depending on where the release lands, the first capture after release may come before or after the fast domain has located its word boundary. In the second case the early word is legitimately dropped, and the first transmitted word must still be a clean post-release capture starting at slot 0.

The stimulus drops and releases `shdn_n` mid-stream several times, each at a different offset within the pixel period. The bench rebuilds every word from the lanes using the framing pattern and compares it with its own record of what was on the bus at each falling edge. Between each falling edge and the next rising edge it also drives junk onto the bus, so every comparison shows that the junk was ignored.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

  // Framing word for the forwarded-clock lane: bit k is the level sent in
  // slot k. High for the first 'head' slots and the last 'tail' slots.
  function automatic logic [31:0] fwd_pattern(input int unsigned bits,
                                              input int unsigned head,
                                              input int unsigned tail);
    logic [31:0] p;
    p = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < bits) p[i] = (i < head) || (i >= bits - tail);
    end
    return p;
  endfunction

  // Width of a slot counter that counts 0..bits-1.
  function automatic int unsigned slot_width(input int unsigned bits);
    return (bits > 2) ? $clog2(bits) : 1;
  endfunction

endpackage

// File: rtl/pixlink_capture.sv
// Pixel-clock domain: falling-edge word capture and a rising-edge marker.
module pixlink_capture #(
  parameter int unsigned W = 21
) (
  input  logic         pix_clk,
  input  logic         shdn_n,
  input  logic [W-1:0] pix_data,
  output logic [W-1:0] cap_word,
  output logic         cap_vld,
  output logic         bnd_tgl
);

  // Word held from one falling edge to the next.
  always_ff @(negedge pix_clk or negedge shdn_n) begin
    if (!shdn_n) begin
      cap_word <= '0;
      cap_vld  <= 1'b0;
    end else begin
      cap_word <= pix_data;
      cap_vld  <= 1'b1;
    end
  end

  // Flips on every rising edge; the fast domain reads it to find word starts.
  always_ff @(posedge pix_clk or negedge shdn_n) begin
    if (!shdn_n) bnd_tgl <= 1'b0;
    else         bnd_tgl <= ~bnd_tgl;
  end

endmodule

// File: rtl/pixlink_framer.sv
// Fast-clock domain: slot counter aligned to the pixel boundary, load strobe.
module pixlink_framer #(
  parameter int unsigned BITS = 7,
  parameter int unsigned SW   = pixlink_pkg::slot_width(BITS)
) (
  input  logic          fast_clk,
  input  logic          shdn_n,
  input  logic          bnd_tgl,
  input  logic          cap_vld,
  output logic [SW-1:0] slot,
  output logic          load_evt,
  output logic          tx_active,
  output logic          align_evt
);

  localparam logic [SW-1:0] LAST = SW'(BITS - 1);

  logic tgl_seen;
  logic aligned;
  logic last_slot;

  // The marker flips at a rising pixel edge. The fast edge that coincides
  // with it still reads the old value, so the change shows one fast cycle
  // later, at slot 1.
  assign align_evt = bnd_tgl ^ tgl_seen;
  assign last_slot = (slot == LAST);
  assign load_evt  = aligned && last_slot && cap_vld;

  always_ff @(posedge fast_clk or negedge shdn_n) begin
    if (!shdn_n) begin
      tgl_seen  <= 1'b0;
      aligned   <= 1'b0;
      slot      <= '0;
      tx_active <= 1'b0;
    end else begin
      tgl_seen <= bnd_tgl;
      if (align_evt) begin
        aligned <= 1'b1;
        slot    <= SW'(1);
      end else if (last_slot) begin
        slot <= '0;
      end else begin
        slot <= slot + SW'(1);
      end
      if (load_evt) tx_active <= 1'b1;
    end
  end

endmodule

// File: rtl/pixlink_piso.sv
// Parallel-load shift register, bit 0 leaves first; zeros fill from the top.
module pixlink_piso #(
  parameter int unsigned BITS = 7
) (
  input  logic            fast_clk,
  input  logic            shdn_n,
  input  logic            load,
  input  logic [BITS-1:0] par,
  output logic            ser
);

  logic [BITS-1:0] sh;

  always_ff @(posedge fast_clk or negedge shdn_n) begin
    if (!shdn_n)   sh <= '0;
    else if (load) sh <= par;
    else           sh <= {1'b0, sh[BITS-1:1]};
  end

  assign ser = sh[0];

endmodule

// File: rtl/pixlink_tx.sv
// Top: three data lanes plus a forwarded-clock lane.
module pixlink_tx #(
  parameter int unsigned LANES    = 3,
  parameter int unsigned BITS     = 7,
  parameter int unsigned FWD_HEAD = 2,
  parameter int unsigned FWD_TAIL = 2
) (
  input  logic                  pix_clk,
  input  logic                  fast_clk,
  input  logic                  shdn_n,
  input  logic [LANES*BITS-1:0] pix_data,
  output logic [LANES-1:0]      ser_lane,
  output logic                  fwd_clk
);

  localparam int unsigned W  = LANES * BITS;
  localparam int unsigned SW = pixlink_pkg::slot_width(BITS);
  localparam logic [BITS-1:0] FWD_PAT =
    BITS'(pixlink_pkg::fwd_pattern(BITS, FWD_HEAD, FWD_TAIL));

  logic [W-1:0]  cap_word;
  logic          cap_vld;
  logic          bnd_tgl;
  logic [SW-1:0] slot;
  logic          load_evt;
  logic          tx_active;
  logic          align_evt;

  pixlink_capture #(.W(W)) u_cap (
    .pix_clk  (pix_clk),
    .shdn_n   (shdn_n),
    .pix_data (pix_data),
    .cap_word (cap_word),
    .cap_vld  (cap_vld),
    .bnd_tgl  (bnd_tgl)
  );

  pixlink_framer #(.BITS(BITS), .SW(SW)) u_frm (
    .fast_clk  (fast_clk),
    .shdn_n    (shdn_n),
    .bnd_tgl   (bnd_tgl),
    .cap_vld   (cap_vld),
    .slot      (slot),
    .load_evt  (load_evt),
    .tx_active (tx_active),
    .align_evt (align_evt)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pixlink_piso #(.BITS(BITS)) u_sh (
      .fast_clk (fast_clk),
      .shdn_n   (shdn_n),
      .load     (load_evt),
      .par      (cap_word[l*BITS +: BITS]),
      .ser      (ser_lane[l])
    );
  end

  pixlink_piso #(.BITS(BITS)) u_fwd (
    .fast_clk (fast_clk),
    .shdn_n   (shdn_n),
    .load     (load_evt),
    .par      (FWD_PAT),
    .ser      (fwd_clk)
  );

endmodule

// File: rtl/pixlink_tx_chk.sv
// Assertions for pixlink_tx, attached with bind.
module pixlink_tx_chk #(
  parameter int unsigned LANES    = 3,
  parameter int unsigned BITS     = 7,
  parameter int unsigned FWD_HEAD = 2,
  parameter int unsigned FWD_TAIL = 2,
  parameter int unsigned SW       = pixlink_pkg::slot_width(BITS)
) (
  input logic                  fast_clk,
  input logic                  shdn_n,
  input logic [LANES*BITS-1:0] cap_word,
  input logic                  cap_vld,
  input logic [SW-1:0]         slot,
  input logic                  load_evt,
  input logic                  tx_active,
  input logic [LANES-1:0]      ser_lane,
  input logic                  fwd_clk
);

  localparam logic [BITS-1:0] PAT =
    BITS'(pixlink_pkg::fwd_pattern(BITS, FWD_HEAD, FWD_TAIL));

  logic [LANES-1:0] head_bits;
  always_comb begin
    for (int l = 0; l < LANES; l++) head_bits[l] = cap_word[l*BITS];
  end

  // R5: outputs silent while shutdown is held
  always @(posedge fast_clk) begin
    if (!shdn_n) begin
      p_shdn_quiet_r5: assert (ser_lane == '0 && fwd_clk == 1'b0)
        else $error("outputs active during shutdown");
    end
  end

  // R6: nothing leaves before the first load
  p_quiet_before_load_r6: assert property (@(posedge fast_clk) disable iff (!shdn_n)
    !tx_active |-> (ser_lane == '0 && fwd_clk == 1'b0));

  // R4: the loaded word's slot-0 bits appear right after the load edge
  p_load_head_r4: assert property (@(posedge fast_clk) disable iff (!shdn_n)
    load_evt |=> (ser_lane == $past(head_bits) && fwd_clk));

  // R3: forwarded lane follows the framing pattern at every slot
  p_fwd_track_r3: assert property (@(posedge fast_clk) disable iff (!shdn_n)
    tx_active |-> (fwd_clk == PAT[slot]));

  // R7: every word boundary after start reloads the shifters
  p_reload_each_period_r7: assert property (@(posedge fast_clk) disable iff (!shdn_n)
    (tx_active && slot == SW'(BITS - 1)) |-> (load_evt && cap_vld));

  // R3: slot counter stays inside the word
  p_slot_range_r3: assert property (@(posedge fast_clk) disable iff (!shdn_n)
    slot < SW'(BITS));

endmodule

bind pixlink_tx pixlink_tx_chk #(
  .LANES(LANES), .BITS(BITS), .FWD_HEAD(FWD_HEAD), .FWD_TAIL(FWD_TAIL), .SW(SW)
) u_chk (
  .fast_clk  (fast_clk),
  .shdn_n    (shdn_n),
  .cap_word  (cap_word),
  .cap_vld   (cap_vld),
  .slot      (slot),
  .load_evt  (load_evt),
  .tx_active (tx_active),
  .ser_lane  (ser_lane),
  .fwd_clk   (fwd_clk)
);

// File: tb/pixlink_tx_bench.sv
`timescale 1ns/1ps
module pixlink_tx_bench;

  localparam int FAST_HALF = 10;            // 50 MHz bit clock
  localparam int PIX_HALF  = 7 * FAST_HALF; // pixel clock, 7x slower

  logic        pix_clk  = 1'b0;
  logic        fast_clk = 1'b0;
  logic        shdn_n   = 1'b0;
  logic [20:0] pix_data = '0;
  logic [2:0]  ser_lane;
  logic        fwd_clk;

  int total = 0;
  int bad   = 0;

  pixlink_tx u_pixlink_tx (
    .pix_clk  (pix_clk),
    .fast_clk (fast_clk),
    .shdn_n   (shdn_n),
    .pix_data (pix_data),
    .ser_lane (ser_lane),
    .fwd_clk  (fwd_clk)
  );

  always #FAST_HALF fast_clk = ~fast_clk;
  always #PIX_HALF  pix_clk  = ~pix_clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Framing level restated from R3: slots 0,1 and 5,6 high.
  function automatic bit exp_fwd(input int ph);
    return (ph <= 1) || (ph >= 5);
  endfunction

  int word_idx = 0;
  function automatic logic [20:0] next_word(input int idx);
    case (idx)
      0:       return 21'h000000;
      1:       return 21'h1FFFFF;
      2:       return 21'h0AAAAA;
      3:       return 21'h155555;
      4:       return 21'h00007F; // lane 0 only
      5:       return 21'h003F80; // lane 1 only
      6:       return 21'h1FC000; // lane 2 only
      7:       return 21'h100001; // end bits
      default: return 21'($urandom());
    endcase
  endfunction

  // Driver: real word after the rising edge, junk after the falling edge (R1).
  initial begin
    void'($urandom(32'h5EED));
    forever begin
      @(posedge pix_clk);
      #5;
      pix_data = next_word(word_idx);
      word_idx++;
      @(negedge pix_clk);
      #5;
      pix_data = 21'($urandom());
    end
  end

  // Bench record of what was on the bus at each falling edge.
  logic [20:0] exp0 = '0, exp1 = '0;
  bit          v0 = 0, v1 = 0;
  int          cap_since = 0;
  always @(negedge pix_clk) begin
    if (shdn_n) begin
      exp1 = exp0; v1 = v0;
      exp0 = pix_data; v0 = 1;
      cap_since++;
    end
  end

  // Receiver: sample in the middle of each bit.
  bit         started = 0;
  bit         had_word = 0;
  int         phase = 0;
  int         rx_words = 0;
  logic [6:0] lb0 = '0, lb1 = '0, lb2 = '0;
  always @(negedge fast_clk) begin
    #1;
    if (!shdn_n) begin
      chk(ser_lane == 3'b0 && fwd_clk == 1'b0, "R5", {ser_lane, fwd_clk}, 0);
      started = 0; had_word = 0; phase = 0;
      v0 = 0; v1 = 0;
    end else begin
      if (!started) begin
        if (fwd_clk) begin
          started = 1; phase = 0;
        end else begin
          chk(ser_lane == 3'b0, "R6", ser_lane, 0);
        end
      end else begin
        phase = (phase == 6) ? 0 : phase + 1;
      end
      if (started) begin
        chk(fwd_clk == exp_fwd(phase), "R3", fwd_clk, exp_fwd(phase));
        lb0 = {ser_lane[0], lb0[6:1]};
        lb1 = {ser_lane[1], lb1[6:1]};
        lb2 = {ser_lane[2], lb2[6:1]};
        if (phase == 6) begin
          // R2 R4 R1 R6: rebuilt word equals the capture before this period
          chk(v1 && {lb2, lb1, lb0} == exp1, "R2/R4", {lb2, lb1, lb0}, exp1);
          // R7: exactly one capture since the previous word completed
          if (had_word) chk(cap_since == 1, "R7", cap_since, 1);
          had_word = 1;
          cap_since = 0;
          rx_words++;
        end
      end
    end
  end

  task automatic run_periods(input int n);
    repeat (n) @(posedge pix_clk);
  endtask

  initial begin
    #5;
    chk(ser_lane == 3'b0 && fwd_clk == 1'b0, "R5 reset", {ser_lane, fwd_clk}, 0);
    // release between a rising and a falling pixel edge
    @(posedge pix_clk); #23; shdn_n = 1;
    run_periods(60);
    // shutdown mid-word
    @(posedge fast_clk); @(posedge fast_clk); #4;
    shdn_n = 0;
    #1;
    chk(ser_lane == 3'b0 && fwd_clk == 1'b0, "R5 async", {ser_lane, fwd_clk}, 0);
    repeat (25) @(posedge fast_clk);
    // release just before a rising pixel edge
    @(negedge pix_clk); #63; shdn_n = 1;
    run_periods(50);
    // release just after a falling pixel edge
    @(negedge pix_clk); #7; shdn_n = 0;
    #1;
    chk(ser_lane == 3'b0 && fwd_clk == 1'b0, "R5 async", {ser_lane, fwd_clk}, 0);
    repeat (9) @(posedge fast_clk);
    @(negedge pix_clk); #3; shdn_n = 1;
    run_periods(40);
    chk(rx_words >= 140, "R7 count", rx_words, 140);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule